// File: doc/BRIEF.md
# Single-Input Period and Pulse-Width Capture Timer

This block is a 16-bit up-counter that measures a single digital input. The input is brought into the clock domain and its transitions are detected. One polarity of transition is the valid edge, selected by a control input. On each valid edge the running count is stored as the period and the counter restarts from zero. On the transition of the other polarity the running count is stored as the pulse width, and the counter keeps running. Each store raises its own one-cycle strobe.

The counter advances only on cycles where the count-enable tick is high, so any prescaler stays outside the block. A sticky overflow flag is set each time the counter wraps. Software can then count wraps and add 10000h for each one to the stored value, which makes measurements longer than 16 bits possible. The low phase is the period minus the stored width. A two-bit mode input selects between capture-and-clear operation, a stopped-and-zeroed state and two holding states.

Top module: `pwc_capture_timer`

## Requirements
- R1: After reset, both capture outputs, both strobes and the overflow flag are zero.
- R2: Mode 2'b10 runs capture-and-clear. Mode 2'b00 holds the counter at zero. Modes 2'b01 and 2'b11 freeze the counter. Outside mode 2'b10, no transition stores a value or raises a strobe.
- R3: On a valid edge in mode 2'b10, the count is stored in period_o and the counter is set to zero. The stored value is the number of ticks since the previous clear, not counting the tick of the clearing cycle. With the tick held high, a period of P clocks reads P-1.
- R4: On the opposite edge, the count is stored in width_o and the counter continues. With the tick held high, a phase of A clocks after the valid edge reads A-1.
- R5: edge_rise_sel_i=1 makes the rising edge valid and the falling edge the width edge. edge_rise_sel_i=0 swaps the two.
- R6: Each store raises its strobe for exactly one cycle, in the same cycle that the new value appears.
- R7: A level change that is applied before rising clock edge k is stored at edge k+2. This is the third rising edge that sees the new level.
- R8: A wrap from FFFFh to 0000h sets ovf_o. It stays set until a one-cycle pulse on ovf_clr_i clears it, and a wrap in the same cycle wins over the clear.
- R9: If a valid edge falls in the same cycle as a wrap, period_o stores FFFFh, the counter goes to zero and ovf_o is set.
- R10: The counter advances only on cycles where tick_i is high. Captures happen on any cycle, so with the tick held low both stores read zero.
- R11: The first synchronized level after reset is taken as the previous level, so a high input held through reset gives no store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count enable |
| sig_i | input | 1 | Measured input, asynchronous |
| mode_i | input | 2 | Operating mode |
| edge_rise_sel_i | input | 1 | 1: rising edge is valid, 0: falling edge is valid |
| ovf_clr_i | input | 1 | Strobe that writes zero to the overflow flag |
| period_o | output | 16 | Count stored on the valid edge |
| width_o | output | 16 | Count stored on the opposite edge |
| period_irq_o | output | 1 | One-cycle strobe when period_o is loaded |
| width_irq_o | output | 1 | One-cycle strobe when width_o is loaded |
| ovf_o | output | 1 | Sticky wrap flag |

## Verification
A valid-edge clear and a counter wrap can fall in the same cycle. The bench provokes this by entering the run mode from a zeroed counter with the tick held high. It then places a rising input exactly 65533 clock edges later, so that the synchronized edge lines up with the count at FFFFh. The bench checks that period_o reads FFFFh and that the overflow flag rises in that cycle. It also checks that a width store a few cycles later reads 2, which proves that the counter restarted from zero and did not wrap to a larger value.

// File: rtl/pwc_pkg.sv
package pwc_pkg;
  typedef enum logic [1:0] {
    MODE_STOP   = 2'b00,
    MODE_HOLD_A = 2'b01,
    MODE_CAPCLR = 2'b10,
    MODE_HOLD_B = 2'b11
  } pwc_mode_e;
endpackage

// File: rtl/pwc_edge_det.sv
module pwc_edge_det #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] vld_q;
  logic              prev_q;
  logic              prev_vld_q;
  logic              lvl;

  assign lvl = sync_q[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q     <= '0;
      vld_q      <= '0;
      prev_q     <= 1'b0;
      prev_vld_q <= 1'b0;
    end else begin
      sync_q     <= {sync_q[STAGES-2:0], sig_i};
      vld_q      <= {vld_q[STAGES-2:0], 1'b1};
      prev_q     <= lvl;
      prev_vld_q <= vld_q[STAGES-1];
    end
  end

  // first valid level only primes prev_q
  assign rise_o = prev_vld_q & lvl & ~prev_q;
  assign fall_o = prev_vld_q & ~lvl & prev_q;

  p_rise_gap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
  p_fall_gap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/pwc_counter.sv
module pwc_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             stop_i,
  input  logic             clr_i,
  input  logic             ovf_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ovf_q, ovf_d;
  logic             wrap;

  assign wrap = run_i & tick_i & (cnt_q == CNT_MAX);

  always_comb begin
    cnt_d = cnt_q;
    if (stop_i)                 cnt_d = '0;
    else if (run_i && clr_i)    cnt_d = '0;
    else if (run_i && tick_i)   cnt_d = cnt_q + 1'b1;
  end

  // wrap wins over software clear; clear on an edge does not mask the wrap
  always_comb begin
    ovf_d = ovf_q;
    if (wrap)           ovf_d = 1'b1;
    else if (ovf_clr_i) ovf_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;

  p_stop_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> cnt_q == '0);
  p_clear_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && clr_i |=> cnt_q == '0);
  p_no_tick_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && !clr_i && !tick_i |=> $stable(cnt_q));
  p_wrap_sets_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && tick_i && cnt_q == CNT_MAX |=> ovf_q);
  p_ovf_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q && !ovf_clr_i |=> ovf_q);
endmodule

// File: rtl/pwc_capture_timer.sv
module pwc_capture_timer #(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             sig_i,
  input  logic [1:0]       mode_i,
  input  logic             edge_rise_sel_i,
  input  logic             ovf_clr_i,
  output logic [CNT_W-1:0] period_o,
  output logic [CNT_W-1:0] width_o,
  output logic             period_irq_o,
  output logic             width_irq_o,
  output logic             ovf_o
);
  import pwc_pkg::*;

  localparam int unsigned N_CH  = 2;
  localparam int unsigned CH_PER = 0;
  localparam int unsigned CH_WID = 1;

  pwc_mode_e        mode;
  logic             run, stop;
  logic             rise, fall;
  logic             valid_edge, width_edge;
  logic [CNT_W-1:0] cnt;
  logic [N_CH-1:0]  cap_ev;
  logic [N_CH-1:0]  irq_q;
  logic [CNT_W-1:0] cap_q [N_CH];

  assign mode = pwc_mode_e'(mode_i);
  assign run  = (mode == MODE_CAPCLR);
  assign stop = (mode == MODE_STOP);

  pwc_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (sig_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  assign valid_edge = edge_rise_sel_i ? rise : fall;
  assign width_edge = edge_rise_sel_i ? fall : rise;

  assign cap_ev[CH_PER] = run & valid_edge;
  assign cap_ev[CH_WID] = run & width_edge;

  pwc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .run_i     (run),
    .stop_i    (stop),
    .clr_i     (valid_edge),
    .ovf_clr_i (ovf_clr_i),
    .cnt_o     (cnt),
    .ovf_o     (ovf_o)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cap_q[g] <= '0;
        irq_q[g] <= 1'b0;
      end else begin
        irq_q[g] <= cap_ev[g];
        if (cap_ev[g]) cap_q[g] <= cnt;
      end
    end
  end

  assign period_o     = cap_q[CH_PER];
  assign width_o      = cap_q[CH_WID];
  assign period_irq_o = irq_q[CH_PER];
  assign width_irq_o  = irq_q[CH_WID];

  p_period_cap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run && valid_edge |=> period_irq_o && period_o == $past(cnt));
  p_width_cap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run && width_edge |=> width_irq_o && width_o == $past(cnt));
  p_no_cap_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |=> !period_irq_o && !width_irq_o);
  p_irq_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_irq_o |=> !period_irq_o);
  p_width_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !width_irq_o |-> $stable(width_o));
endmodule

// File: tb/pwc_capture_timer_test.sv
`timescale 1ns/1ps
module pwc_capture_timer_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b1;
  logic        sig_i = 1'b1;
  logic [1:0]  mode_i = 2'b10;
  logic        edge_rise_sel_i = 1'b1;
  logic        ovf_clr_i = 1'b0;
  logic [15:0] period_o, width_o;
  logic        period_irq_o, width_irq_o, ovf_o;

  int n_chk = 0, n_fail = 0;
  int n_p = 0, n_w = 0;
  bit chk_en = 1'b0;
  int exp_p = 0, exp_w = 0;
  string tag_p = "R3", tag_w = "R4";
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pwc_capture_timer uut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .sig_i(sig_i),
    .mode_i(mode_i), .edge_rise_sel_i(edge_rise_sel_i), .ovf_clr_i(ovf_clr_i),
    .period_o(period_o), .width_o(width_o), .period_irq_o(period_irq_o),
    .width_irq_o(width_irq_o), .ovf_o(ovf_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_ni && !done) begin
    if (period_irq_o) begin
      n_p++;
      if (chk_en && n_p > 1) chk(period_o == exp_p, tag_p, period_o, exp_p);
    end
    if (width_irq_o) begin
      n_w++;
      if (chk_en) chk(width_o == exp_w, tag_w, width_o, exp_w);
    end
  end

  task automatic run_cfg(input bit sel, input int a, input int b, input bit tk);
    chk_en = 1'b0;
    mode_i = 2'b00;
    edge_rise_sel_i = sel;
    sig_i = ~sel;
    tick_i = tk;
    repeat (5) @(negedge clk);
    n_p = 0; n_w = 0;
    exp_p = tk ? a + b - 1 : 0;
    exp_w = tk ? a - 1 : 0;
    tag_p = tk ? "R3 R5 period" : "R10 period";
    tag_w = tk ? "R4 R5 width" : "R10 width";
    chk_en = 1'b1;
    mode_i = 2'b10;
    repeat (3) @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      sig_i = sel;
      repeat (a) @(negedge clk);
      sig_i = ~sel;
      repeat (b) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    chk_en = 1'b0;
    chk(n_p == 3, "R6 period strobe count", n_p, 3);
    chk(n_w == 3, "R6 width strobe count", n_w, 3);
  endtask

  task automatic no_cap_mode(input logic [1:0] m);
    int p0, w0;
    logic [15:0] pv;
    mode_i = m;
    repeat (4) @(negedge clk);
    p0 = n_p; w0 = n_w; pv = period_o;
    for (int k = 0; k < 3; k++) begin
      sig_i = ~sig_i;
      repeat (4) @(negedge clk);
    end
    chk(n_p == p0 && n_w == w0, "R2 no strobe outside run mode", n_p + n_w, p0 + w0);
    chk(period_o == pv, "R2 period held outside run mode", period_o, pv);
  endtask

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R1/R11: high input held through reset in run mode, rising valid
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(period_o == 0 && width_o == 0, "R1 captures zero", {period_o, width_o}, 0);
    chk(!period_irq_o && !width_irq_o && !ovf_o, "R1 flags zero",
        {period_irq_o, width_irq_o, ovf_o}, 0);
    repeat (10) @(negedge clk);
    chk(n_p == 0 && n_w == 0, "R11 first level is no edge", n_p + n_w, 0);
    sig_i = 1'b0;
    repeat (4) @(negedge clk);
    chk(n_w == 1, "R11 later edge detected", n_w, 1);

    // sweep: both edge selections, phase lengths 1..6
    for (int s = 0; s < 2; s++)
      for (int a = 1; a <= 6; a++)
        for (int b = 1; b <= 6; b++)
          run_cfg(s[0], a, b, 1'b1);
    run_cfg(1'b1, 3, 4, 1'b0);
    run_cfg(1'b0, 2, 5, 1'b0);

    // R7/R9/R8: valid edge lined up with wrap
    mode_i = 2'b00; edge_rise_sel_i = 1'b1; sig_i = 1'b0; tick_i = 1'b1;
    repeat (5) @(negedge clk);
    mode_i = 2'b10;
    repeat (65533) @(negedge clk);
    chk(!ovf_o, "R8 no overflow before wrap", ovf_o, 0);
    sig_i = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(!period_irq_o, "R7 no store after two edges", period_irq_o, 0);
    chk(!ovf_o, "R8 no overflow one cycle before wrap", ovf_o, 0);
    @(negedge clk);
    chk(period_irq_o, "R7 store on third edge", period_irq_o, 1);
    chk(period_o == 16'hFFFF, "R9 period at wrap", period_o, 16'hFFFF);
    chk(ovf_o, "R9 overflow set on collision", ovf_o, 1);
    sig_i = 1'b0;
    @(negedge clk);
    chk(!period_irq_o, "R6 strobe one cycle", period_irq_o, 0);
    @(negedge clk);
    @(negedge clk);
    chk(width_irq_o && width_o == 16'd2, "R9 counter restarted from zero", width_o, 2);
    repeat (5) @(negedge clk);
    chk(ovf_o, "R8 overflow sticky", ovf_o, 1);
    ovf_clr_i = 1'b1;
    @(negedge clk);
    ovf_clr_i = 1'b0;
    chk(!ovf_o, "R8 overflow cleared by strobe", ovf_o, 0);

    // R2: other modes
    no_cap_mode(2'b01);
    no_cap_mode(2'b11);
    no_cap_mode(2'b00);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule